// File: doc/BRIEF.md
# Region-Based Address Translator

This block widens a 32-bit address into a 48-bit address by looking it up in a small table of programmable regions. Each region holds four values: an enable, a size, a source base and a translated base. The size is a power of two, given as a count of low address bits. When an incoming address falls inside an enabled region, the bits above the region size are replaced by the translated base and the bits below it pass through unchanged. An address that falls in no region leaves the block zero-extended, and a miss flag is raised with it.

The table is programmed and read back through a plain 32-bit register port with separate write and read strobes. The lookup is combinational across all regions at once. Its result is captured in an output register, so a valid address presented on one clock edge appears translated right after that edge. Two read-only words report the revision and the configuration of the block.

Top module: `addr_xlate_top`

## Requirements
- R1: After a synchronous reset, every region is disabled with all of its fields at zero. The outputs `out_valid`, `out_miss` and `out_addr` are all zero.
- R2: A read of offset 0x000 returns 0x66801100. A read of offset 0x004 returns 0x00300210: bits 23:16 hold the output width 48, bits 15:8 hold 2 and bits 7:0 hold the region count 16.
- R3: Region j owns the four words at 0x020 + 0x10*j, in the order control, source base, translated lower word, translated upper word. In the control word, bit 31 is the enable and bits 5:0 are the size. The upper word keeps only bits 15:0. Every other bit of these words reads back as zero whatever was written.
- R4: An address A hits region j with clamped size S when region j is enabled and A[31:S] equals base[31:S]. The output is then {upper[15:0], lower[31:S], A[S-1:0]}.
- R5: When several regions hit, the region with the lowest index supplies the output.
- R6: An address that hits no region is output as {16'h0, A} with `out_miss` high. `out_miss` is low on every hit.
- R7: A size value of 32 or above acts as 32. Every address then hits that region and leaves as {upper[15:0], A}.
- R8: A disabled region never hits, even when its base matches the address.
- R9: `out_valid`, `out_addr` and `out_miss` change on the clock edge that samples `in_valid`. `out_valid` is low after any edge at which `in_valid` was low. A table write takes effect for addresses sampled from the next edge on.
- R10: A size of 0 compares all 32 address bits and outputs the full translated base.
- R11: `cfg_rdata` is updated on the edge that samples `cfg_rd`. Offsets that map to no register, including region slots above the last region, read as zero.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one edge after `cfg_rd` |
| in_valid | input | 1 | Input address is valid |
| in_addr | input | 32 | Address to translate |
| out_valid | output | 1 | Registered result is valid |
| out_addr | output | 48 | Translated or zero-extended address |
| out_miss | output | 1 | No enabled region matched |

## Verification
A corrupted table entry or a wrong size mask shows up on the very next valid output. It appears either as wrong upper bits, or as offset bits that leak from the translated base instead of passing through from the input. A fault in the priority chain changes the output only for an address that lies in two overlapping regions. A lost write or a broken reserved-bit mask is visible on the readback one edge after the read strobe. A miss that is taken for a hit, or a hit taken for a miss, flips `out_miss` and the top sixteen bits in the same cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int IN_W  = 32;
  localparam int OUT_W = 48;
  localparam int HI_W  = OUT_W - IN_W;
  localparam int SZ_W  = 6;
  localparam int DW    = 32;

  typedef struct packed {
    logic            en;
    logic [SZ_W-1:0] size;
    logic [IN_W-1:0] src;
    logic [IN_W-1:0] dst_lo;
    logic [HI_W-1:0] dst_hi;
  } region_t;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
  import xlate_pkg::*;
#(
  parameter int          NREG   = 16,
  parameter int          CFG_AW = 12,
  parameter logic [31:0] REV_ID = 32'h6680_1100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [CFG_AW-1:0]    addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output region_t [NREG-1:0]   tbl
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [CFG_AW-1:0] RGN_BASE = CFG_AW'(12'h020);
  localparam logic [CFG_AW-1:0] RGN_END  = CFG_AW'(32'h20 + NREG * 16);
  localparam logic [DW-1:0] CFG_WORD = {8'h00, 8'(OUT_W), 8'd2, 8'(NREG)};

  logic [CFG_AW-1:0] rel;
  logic              in_rgn;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        sel;

  assign rel    = addr - RGN_BASE;
  assign in_rgn = (addr >= RGN_BASE) && (addr < RGN_END);
  assign idx    = rel[4 +: IDX_W];
  assign sel    = addr[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl <= '0;
    end else if (wr && in_rgn) begin
      case (sel)
        2'd0: begin
          tbl[idx].en   <= wdata[31];
          tbl[idx].size <= wdata[SZ_W-1:0];
        end
        2'd1:    tbl[idx].src    <= wdata;
        2'd2:    tbl[idx].dst_lo <= wdata;
        default: tbl[idx].dst_hi <= wdata[HI_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (in_rgn) begin
        case (sel)
          2'd0:    rdata <= {tbl[idx].en, {(DW-1-SZ_W){1'b0}}, tbl[idx].size};
          2'd1:    rdata <= tbl[idx].src;
          2'd2:    rdata <= tbl[idx].dst_lo;
          default: rdata <= {{(DW-HI_W){1'b0}}, tbl[idx].dst_hi};
        endcase
      end else if (addr[CFG_AW-1:2] == '0) begin
        rdata <= REV_ID;
      end else if (addr[CFG_AW-1:2] == 1) begin
        rdata <= CFG_WORD;
      end else begin
        rdata <= '0;
      end
    end
  end

  // R2: the revision word comes back one edge after the read
  a_r2_rev_read: assert property (@(posedge clk) disable iff (rst)
    (rd && addr[CFG_AW-1:2] == '0) |=> rdata == REV_ID);

  // R3: control-word reserved bits never read as one
  a_r3_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && in_rgn && sel == 2'd0) |=> rdata[30:SZ_W] == '0);

  // R11: unmapped offsets read zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && !in_rgn && addr[CFG_AW-1:3] != '0) |=> rdata == '0);
endmodule

// File: rtl/xlate_match.sv
module xlate_match
  import xlate_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic [IN_W-1:0]             in_addr,
  input  region_t [NREG-1:0]          tbl,
  output logic [NREG-1:0]             hit,
  output logic [NREG-1:0][OUT_W-1:0]  xl
);
  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    logic [SZ_W-1:0] s;
    logic [IN_W-1:0] keep;

    assign s    = (tbl[g].size > SZ_W'(IN_W)) ? SZ_W'(IN_W) : tbl[g].size;
    assign keep = (s == SZ_W'(IN_W)) ? '1 : ((IN_W'(1) << s) - IN_W'(1));
    assign hit[g] = tbl[g].en && ((in_addr & ~keep) == (tbl[g].src & ~keep));
    assign xl[g]  = {tbl[g].dst_hi, (tbl[g].dst_lo & ~keep) | (in_addr & keep)};
  end
endmodule

// File: rtl/xlate_pick.sv
module xlate_pick
  import xlate_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [IN_W-1:0]             in_addr,
  input  logic [NREG-1:0]             hit,
  input  logic [NREG-1:0][OUT_W-1:0]  xl,
  output logic                        out_valid,
  output logic [OUT_W-1:0]            out_addr,
  output logic                        out_miss
);
  logic             found;
  logic [OUT_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = {{HI_W{1'b0}}, in_addr};
    for (int j = NREG - 1; j >= 0; j--) begin
      if (hit[j]) begin
        found = 1'b1;
        pick  = xl[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_miss  <= in_valid && !found;
      if (in_valid) out_addr <= pick;
    end
  end

  // R9: valid output follows a sampled input
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9: no output without a sampled input
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_miss);

  // R6: a miss leaves as the zero-extended input
  a_r6_miss_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_miss) |-> out_addr == {{HI_W{1'b0}}, $past(in_addr)});
endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top
  import xlate_pkg::*;
#(
  parameter int          NREG   = 16,
  parameter int          CFG_AW = 12,
  parameter logic [31:0] REV_ID = 32'h6680_1100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  output logic              out_valid,
  output logic [47:0]       out_addr,
  output logic              out_miss
);
  region_t [NREG-1:0]          tbl;
  logic [NREG-1:0]             hit;
  logic [NREG-1:0][OUT_W-1:0]  xl;

  xlate_regs #(.NREG(NREG), .CFG_AW(CFG_AW), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .rd(cfg_rd), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .tbl(tbl)
  );

  xlate_match #(.NREG(NREG)) u_match (
    .in_addr(in_addr), .tbl(tbl), .hit(hit), .xl(xl)
  );

  xlate_pick #(.NREG(NREG)) u_pick (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .hit(hit), .xl(xl), .out_valid(out_valid), .out_addr(out_addr),
    .out_miss(out_miss)
  );
endmodule

// File: tb/addr_xlate_top_tb.sv
module addr_xlate_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_valid, out_miss;
  logic [47:0] out_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [48:0] exp_q[$];
  string       tag_q[$];

  logic        sh_en  [16];
  logic [5:0]  sh_sz  [16];
  logic [31:0] sh_src [16];
  logic [31:0] sh_lo  [16];
  logic [15:0] sh_hi  [16];

  always #10 clk = ~clk;

  addr_xlate_top u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr), .out_miss(out_miss)
  );

  function automatic logic [48:0] model(input logic [31:0] a);
    for (int j = 0; j < 16; j++) begin
      logic [5:0]  s;
      logic [31:0] m;
      s = (sh_sz[j] > 6'd32) ? 6'd32 : sh_sz[j];
      m = (s == 6'd32) ? 32'hFFFF_FFFF : ((32'h1 << s) - 32'h1);
      if (sh_en[j] && ((a & ~m) == (sh_src[j] & ~m)))
        return {1'b0, sh_hi[j], (sh_lo[j] & ~m) | (a & m)};
    end
    return {1'b1, 16'h0, a};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a >= 12'h020 && a < 12'h120) begin
      int j;
      j = int'((a - 12'h020) >> 4);
      case (a[3:2])
        2'd0: begin sh_en[j] = d[31]; sh_sz[j] = d[5:0]; end
        2'd1: sh_src[j] = d;
        2'd2: sh_lo[j]  = d;
        default: sh_hi[j] = d[15:0];
      endcase
    end
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    n_cmp++;
    if (cfg_rdata !== e) begin
      n_bad++;
      $display("FAIL %s: read 0x%03h got %08h expected %08h", tag, a, cfg_rdata, e);
    end
  endtask

  task automatic send(input logic [31:0] a, input string tag);
    in_valid = 1'b1; in_addr = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compares each valid output against the head of the queue
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9: unexpected output %012h expected none", out_addr);
      end else begin
        logic [48:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_miss, out_addr} !== e) begin
          n_bad++;
          $display("FAIL %s: got miss=%0b addr=%012h expected miss=%0b addr=%012h",
                   t, out_miss, out_addr, e[48], e[47:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 16; j++) begin
      sh_en[j] = 0; sh_sz[j] = 0; sh_src[j] = 0; sh_lo[j] = 0; sh_hi[j] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state at the ports
    n_cmp++;
    if (out_valid !== 1'b0 || out_miss !== 1'b0 || out_addr !== 48'h0) begin
      n_bad++;
      $display("FAIL R1: got v=%0b m=%0b a=%012h expected 0 0 0", out_valid, out_miss, out_addr);
    end
    rd_chk(12'h020, 32'h0, "R1");
    rd_chk(12'h02C, 32'h0, "R1");

    // R2: identification words
    rd_chk(12'h000, 32'h6680_1100, "R2");
    rd_chk(12'h004, 32'h0030_0210, "R2");

    // R6: empty table, pure pass-through
    send(32'h1234_5678, "R6");

    // R4: region 0, 12-bit size
    wr(12'h024, 32'h4000_1000);
    wr(12'h028, 32'h8000_2000);
    wr(12'h02C, 32'h0000_00AB);
    wr(12'h020, 32'h8000_000C);
    send(32'h4000_1ABC, "R4");
    send(32'h4000_1000, "R4");
    send(32'h4000_2ABC, "R6");

    // R3: readback, reserved bits and word order on region 15
    wr(12'h110, 32'hFFFF_FFFF);
    wr(12'h11C, 32'hFFFF_1234);
    wr(12'h114, 32'hDEAD_BEEF);
    wr(12'h118, 32'h0BAD_F00D);
    rd_chk(12'h110, 32'h8000_003F, "R3");
    rd_chk(12'h11C, 32'h0000_1234, "R3");
    rd_chk(12'h114, 32'hDEAD_BEEF, "R3");
    rd_chk(12'h118, 32'h0BAD_F00D, "R3");

    // R7: size 63 clamps to 32, region 15 catches everything else
    send(32'h1234_5678, "R7");
    send(32'hFFFF_FFFF, "R7");
    // R5: region 0 still wins over region 15
    send(32'h4000_1ABC, "R5");
    wr(12'h110, 32'h0000_003F);

    // R5: region 1 overlaps region 0
    wr(12'h034, 32'h4000_0000);
    wr(12'h038, 32'h1111_0000);
    wr(12'h03C, 32'h0000_0001);
    wr(12'h030, 32'h8000_0010);
    send(32'h4000_1ABC, "R5");
    send(32'h4000_5000, "R5");

    // R8: disabling region 0 hands its range to region 1
    wr(12'h020, 32'h0000_000C);
    send(32'h4000_1ABC, "R8");
    // R8: disabled region 15 no longer catches a miss
    send(32'h7777_0000, "R8");

    // R10: size 0 compares all bits
    wr(12'h044, 32'h0000_0100);
    wr(12'h048, 32'hCAFE_F00D);
    wr(12'h04C, 32'h0000_BEEF);
    wr(12'h040, 32'h8000_0000);
    send(32'h0000_0100, "R10");
    send(32'h0000_0101, "R10");

    // R9: a write applies to the address sampled on the next edge
    wr(12'h04C, 32'h0000_0042);
    send(32'h0000_0100, "R9");
    // R9: back-to-back stream
    send(32'h4000_5000, "R9");
    send(32'h0000_0100, "R9");
    send(32'h9000_0000, "R9");
    send(32'h4000_FFFF, "R9");

    // R11: unmapped offsets
    rd_chk(12'h010, 32'h0, "R11");
    rd_chk(12'h120, 32'h0, "R11");
    rd_chk(12'h804, 32'h0, "R11");

    repeat (4) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9: got %0d outputs missing expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule